// File: doc/BRIEF.md
# Divider Bank Rate Sequencer

This block retunes a clock source and the group of integer dividers hanging off it in one uninterrupted operation. A caller presents a desired bus-clock rate in MHz together with a code for the rate the PLL currently runs at. The block looks the rate up in a fixed table of four settings. Each setting names a PLL target and a divide factor for every one of sixteen dividers.

The block then drives two ports. One is a request/done/error handshake toward the PLL. The other is a one-write-per-cycle port that loads the divider registers. The order of the two steps is chosen so that no divided clock runs faster than intended while the change is under way. When the PLL has to slow down, it is retuned first and the dividers are loaded after it. In every other case the dividers are loaded first and the PLL is retuned afterwards. An unknown rate is turned away before anything is touched.

Top module: `clkdiv_bank_seq`

## Requirements
- R1: After reset `busy`, `done`, `pll_req` and `div_wr_en` are 0 and `status` is 0 (success code). While `busy` is 0, neither `pll_req` nor `div_wr_en` is asserted.
- R2: A request whose rate is none of 200, 400, 600 or 800 produces `done` in the cycle after acceptance with `status` = 1 (bad rate), and no PLL request and no divider write.
- R3: The accepted rates map to PLL target codes, in units of 100 MHz, as follows: 600 MHz gives code 6; 200, 400 and 800 MHz give code 8. The PLL request carries that code on `pll_target`.
- R4: A divider load is 16 writes on consecutive cycles. Write k (k = 0..15) goes to address 0x180 + 0x10·k, so addresses rise from 0x180 to 0x270.
- R5: Each write carries an 8-bit factor. By divider index, the base factors are: 0→4, 2..5→2, 6→1, 7→2, 8→4, 9→2, 10→4, 11→8, 12→24, 13→4, 14→24, 15→16. Divider 1 (the bus divider) gets 4, 2, 1, 1 for 200, 400, 600 and 800 MHz. For 600 MHz, every other divider whose base is 4 or more uses three quarters of its base. All other cases use the base.
- R6: If the selected target code is strictly below `cur_pll_code`, the PLL handshake happens before the divider writes. Otherwise, equal codes included, the writes come first and the PLL handshake follows. The two ports are never active in the same cycle.
- R7: `pll_req` stays high, with `pll_target` held steady, until `pll_done` is seen. It drops in the following cycle.
- R8: `status` is 0 when the PLL step completes with `pll_err` low, and 2 (PLL failure) when `pll_done` arrives with `pll_err` high. A failure in a PLL-first sequence ends it without any divider write.
- R9: `done` is a one-cycle pulse in the cycle after the last PLL completion or divider write. `busy` then falls, and requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Rate change request, taken when idle |
| req_rate | input | 16 | Requested bus rate in MHz |
| cur_pll_code | input | 4 | Present PLL rate code (units of 100 MHz) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 success, 1 bad rate, 2 PLL failure |
| pll_req | output | 1 | PLL retune request |
| pll_target | output | 4 | PLL target code |
| pll_done | input | 1 | PLL retune finished |
| pll_err | input | 1 | PLL retune failed, valid with pll_done |
| div_wr_en | output | 1 | Divider write strobe |
| div_wr_addr | output | 12 | Divider register address |
| div_wr_data | output | 8 | Divide factor |

## Verification
The hardest case to reach is a PLL failure in the PLL-first ordering. It needs a current code above the target, which only 600 MHz at a current code of 7 or more, or any rate at a code of 9, can give. The bench's PLL model must also return an error on that particular handshake. Directed runs set up both conditions on purpose and check that the divider port stays silent. Random runs vary the current code across both sides of every target and vary the PLL latency, so both orderings and late completions are covered. A request injected mid-sequence checks that nothing extra follows `done`.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    localparam int PRESET_CNT   = 4;
    localparam int DIVIDER_CNT  = 16;
    localparam int DIV_W        = 8;
    localparam int ADDR_W       = 12;
    localparam int RATE_W       = 16;
    localparam int PLL_CODE_W   = 4;
    localparam int PIDX_W       = $clog2(PRESET_CNT);
    localparam logic [ADDR_W-1:0] DIV_BASE_ADDR = 12'h180;
    localparam logic [ADDR_W-1:0] DIV_ADDR_STEP = 12'h010;

    typedef enum logic [1:0] {
        SEQ_OK       = 2'd0,
        SEQ_BAD_RATE = 2'd1,
        SEQ_PLL_FAIL = 2'd2
    } seq_status_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLL_PRE,
        ST_DIVS,
        ST_PLL_POST,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic                  hit;
        logic [PIDX_W-1:0]     idx;
        logic [PLL_CODE_W-1:0] pll;
    } preset_match_t;

    // bus rate in MHz served by preset p
    function automatic logic [RATE_W-1:0] preset_rate(input int p);
        return RATE_W'((p + 1) * 200);
    endfunction

    // PLL target code (x100 MHz) of preset p
    function automatic logic [PLL_CODE_W-1:0] preset_pll(input int p);
        return (p == 2) ? PLL_CODE_W'(6) : PLL_CODE_W'(8);
    endfunction

    // divide factor of divider d under preset p
    function automatic logic [DIV_W-1:0] preset_div(input int p, input int d);
        int base;
        base = 2;
        case (d)
            0, 8, 10, 13: base = 4;
            6:            base = 1;
            11:           base = 8;
            12, 14:       base = 24;
            15:           base = 16;
            default:      base = 2;
        endcase
        if (d == 1) begin
            if (p == 0)      base = 4;
            else if (p == 1) base = 2;
            else             base = 1;
        end else if (p == 2 && base >= 4) begin
            base = (base * 3) / 4;
        end
        return DIV_W'(base);
    endfunction

endpackage

// File: rtl/clkseq_preset_lookup.sv
module clkseq_preset_lookup
    import clkseq_pkg::*;
#(
    parameter int NUM_PRESETS = PRESET_CNT,
    parameter int RW          = RATE_W
) (
    input  logic [RW-1:0] rate,
    output preset_match_t match
);
    logic [NUM_PRESETS-1:0] hit_vec;

    for (genvar p = 0; p < NUM_PRESETS; p++) begin : g_cmp
        assign hit_vec[p] = (rate == RW'(preset_rate(p)));
    end

    always_comb begin
        match = '0;
        for (int p = NUM_PRESETS - 1; p >= 0; p--) begin
            if (hit_vec[p]) begin
                match.hit = 1'b1;
                match.idx = PIDX_W'(p);
                match.pll = preset_pll(p);
            end
        end
    end
endmodule

// File: rtl/clkseq_div_writer.sv
module clkseq_div_writer
    import clkseq_pkg::*;
#(
    parameter int NUM_DIVS = DIVIDER_CNT,
    parameter int DW       = DIV_W,
    parameter int AW       = ADDR_W,
    parameter int IW       = PIDX_W,
    parameter logic [AW-1:0] BASE = DIV_BASE_ADDR,
    parameter logic [AW-1:0] STEP = DIV_ADDR_STEP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [IW-1:0] idx,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          last
);
    localparam int CW = (NUM_DIVS > 1) ? $clog2(NUM_DIVS) : 1;

    logic          active_q;
    logic [CW-1:0] cnt_q;

    assign last = active_q && (cnt_q == CW'(NUM_DIVS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (last) active_q <= 1'b0;
            else      cnt_q    <= cnt_q + 1'b1;
        end
    end

    assign wr_en   = active_q;
    assign wr_addr = BASE + AW'(cnt_q) * STEP;
    assign wr_data = active_q ? DW'(preset_div(int'(idx), int'(cnt_q))) : '0;
endmodule

// File: rtl/clkseq_pll_port.sv
module clkseq_pll_port
    import clkseq_pkg::*;
#(
    parameter int PW = PLL_CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [PW-1:0] target,
    input  logic          pll_done,
    input  logic          pll_err,
    output logic          pll_req,
    output logic [PW-1:0] pll_target,
    output logic          finish,
    output logic          failed
);
    logic          req_q;
    logic [PW-1:0] tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            tgt_q <= '0;
        end else if (start) begin
            req_q <= 1'b1;
            tgt_q <= target;
        end else if (req_q && pll_done) begin
            req_q <= 1'b0;
        end
    end

    assign pll_req    = req_q;
    assign pll_target = tgt_q;
    assign finish     = req_q && pll_done;
    assign failed     = finish && pll_err;
endmodule

// File: rtl/clkdiv_bank_seq.sv
module clkdiv_bank_seq
    import clkseq_pkg::*;
#(
    parameter int NUM_PRESETS = PRESET_CNT,
    parameter int NUM_DIVS    = DIVIDER_CNT,
    parameter int DW          = DIV_W,
    parameter int AW          = ADDR_W,
    parameter int RW          = RATE_W,
    parameter int PW          = PLL_CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [RW-1:0] req_rate,
    input  logic [PW-1:0] cur_pll_code,
    output logic          busy,
    output logic          done,
    output logic [1:0]    status,
    output logic          pll_req,
    output logic [PW-1:0] pll_target,
    input  logic          pll_done,
    input  logic          pll_err,
    output logic          div_wr_en,
    output logic [AW-1:0] div_wr_addr,
    output logic [DW-1:0] div_wr_data
);
    localparam int IW = (NUM_PRESETS > 1) ? $clog2(NUM_PRESETS) : 1;

    seq_state_e    state_q, state_d;
    seq_status_e   status_q, status_d;
    preset_match_t look;
    logic [IW-1:0] idx_q;
    logic [PW-1:0] tgt_q;
    logic          pll_first_q;
    logic          accept, pll_first;
    logic          pll_start, div_start;
    logic          pll_finish, pll_failed, div_last;

    clkseq_preset_lookup #(.NUM_PRESETS(NUM_PRESETS), .RW(RW)) u_lookup (
        .rate  (req_rate),
        .match (look)
    );

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign pll_first = look.hit && (look.pll < cur_pll_code);

    assign pll_start = (accept && pll_first) ||
                       (state_q == ST_DIVS && div_last && !pll_first_q);
    assign div_start = (accept && look.hit && !pll_first) ||
                       (state_q == ST_PLL_PRE && pll_finish && !pll_failed);

    clkseq_pll_port #(.PW(PW)) u_pll (
        .clk        (clk),
        .rst        (rst),
        .start      (pll_start),
        .target     (accept ? look.pll : tgt_q),
        .pll_done   (pll_done),
        .pll_err    (pll_err),
        .pll_req    (pll_req),
        .pll_target (pll_target),
        .finish     (pll_finish),
        .failed     (pll_failed)
    );

    clkseq_div_writer #(
        .NUM_DIVS(NUM_DIVS), .DW(DW), .AW(AW), .IW(IW)
    ) u_divs (
        .clk     (clk),
        .rst     (rst),
        .start   (div_start),
        .idx     (idx_q),
        .wr_en   (div_wr_en),
        .wr_addr (div_wr_addr),
        .wr_data (div_wr_data),
        .last    (div_last)
    );

    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        case (state_q)
            ST_IDLE: if (accept) begin
                if (!look.hit) begin
                    state_d  = ST_FIN;
                    status_d = SEQ_BAD_RATE;
                end else begin
                    state_d = pll_first ? ST_PLL_PRE : ST_DIVS;
                end
            end
            ST_PLL_PRE: if (pll_finish) begin
                if (pll_failed) begin
                    state_d  = ST_FIN;
                    status_d = SEQ_PLL_FAIL;
                end else begin
                    state_d = ST_DIVS;
                end
            end
            ST_DIVS: if (div_last) begin
                if (pll_first_q) begin
                    state_d  = ST_FIN;
                    status_d = SEQ_OK;
                end else begin
                    state_d = ST_PLL_POST;
                end
            end
            ST_PLL_POST: if (pll_finish) begin
                state_d  = ST_FIN;
                status_d = pll_failed ? SEQ_PLL_FAIL : SEQ_OK;
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            status_q    <= SEQ_OK;
            idx_q       <= '0;
            tgt_q       <= '0;
            pll_first_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
            if (accept) begin
                idx_q       <= look.idx;
                tgt_q       <= look.pll;
                pll_first_q <= pll_first;
            end
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = (state_q == ST_FIN);
    assign status = status_q;
endmodule

// File: rtl/clkdiv_bank_seq_chk.sv
module clkdiv_bank_seq_chk #(
    parameter int AW       = 12,
    parameter int PW       = 4,
    parameter int NUM_DIVS = 16,
    parameter logic [AW-1:0] BASE = 12'h180,
    parameter logic [AW-1:0] STEP = 12'h010
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          pll_req,
    input logic [PW-1:0] pll_target,
    input logic          pll_done,
    input logic          div_wr_en,
    input logic [AW-1:0] div_wr_addr
);
    localparam logic [AW-1:0] LAST_ADDR = BASE + AW'(NUM_DIVS - 1) * STEP;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!pll_req && !div_wr_en));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (div_wr_en && div_wr_addr != LAST_ADDR) |=>
        (div_wr_en && div_wr_addr == $past(div_wr_addr) + STEP));

    // R6
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        pll_req |-> !div_wr_en);

    // R7
    pll_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pll_req && !pll_done) |=> (pll_req && $stable(pll_target)));

    // R7
    pll_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pll_req && pll_done) |=> !pll_req);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

bind clkdiv_bank_seq clkdiv_bank_seq_chk #(
    .AW(AW), .PW(PW), .NUM_DIVS(NUM_DIVS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .pll_req     (pll_req),
    .pll_target  (pll_target),
    .pll_done    (pll_done),
    .div_wr_en   (div_wr_en),
    .div_wr_addr (div_wr_addr)
);

// File: tb/test_clkdiv_bank_seq.sv
module test_clkdiv_bank_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_rate = '0;
    logic [3:0]  cur_pll_code = '0;
    logic        busy, done;
    logic [1:0]  status;
    logic        pll_req;
    logic [3:0]  pll_target;
    logic        pll_done = 1'b0;
    logic        pll_err = 1'b0;
    logic        div_wr_en;
    logic [11:0] div_wr_addr;
    logic [7:0]  div_wr_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // PLL model and event log
    int pll_lat = 0;
    int pll_bad = 0;
    int pll_cnt = 0;
    int ev_n = 0;
    int ev_pll [32];
    int ev_val [32];
    int ev_addr[32];
    int ev_cyc [32];
    int done_seen = 0;
    int done_cyc  = 0;

    always #10 clk = ~clk;

    clkdiv_bank_seq i_clkdiv_bank_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_rate(req_rate),
        .cur_pll_code(cur_pll_code), .busy(busy), .done(done), .status(status),
        .pll_req(pll_req), .pll_target(pll_target), .pll_done(pll_done),
        .pll_err(pll_err), .div_wr_en(div_wr_en), .div_wr_addr(div_wr_addr),
        .div_wr_data(div_wr_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (pll_req) begin
            if (pll_cnt == pll_lat) begin
                pll_done = 1'b1;
                pll_err  = (pll_bad != 0);
                if (ev_n < 32) begin
                    ev_pll[ev_n] = 1; ev_val[ev_n] = int'(pll_target);
                    ev_addr[ev_n] = 0; ev_cyc[ev_n] = cyc;
                end
                ev_n++;
            end else begin
                pll_done = 1'b0;
                pll_err  = 1'b0;
            end
            pll_cnt++;
        end else begin
            pll_done = 1'b0;
            pll_err  = 1'b0;
            pll_cnt  = 0;
        end
        if (div_wr_en) begin
            if (ev_n < 32) begin
                ev_pll[ev_n] = 0; ev_val[ev_n] = int'(div_wr_data);
                ev_addr[ev_n] = int'(div_wr_addr); ev_cyc[ev_n] = cyc;
            end
            ev_n++;
        end
        if (done) begin
            done_seen = 1;
            done_cyc  = cyc;
        end
    end

    // expected values from the requirements
    function automatic int exp_idx(int rate);
        case (rate)
            200: return 0;
            400: return 1;
            600: return 2;
            800: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic int exp_pll(int idx);
        return (idx == 2) ? 6 : 8;
    endfunction

    function automatic int exp_div(int idx, int k);
        int base[16] = '{4, 0, 2, 2, 2, 2, 1, 2, 4, 2, 4, 8, 24, 4, 24, 16};
        int bus[4]   = '{4, 2, 1, 1};
        if (k == 1) return bus[idx];
        if (idx == 2 && base[k] >= 4) return base[k] * 3 / 4;
        return base[k];
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_txn(int rate, int cur, int lat, int bad, int inject);
        int req_cyc, idx, tgt, first, n_exp, ok, guard, ev_before;
        int e_pll[32]; int e_val[32]; int e_addr[32];
        @(negedge clk);
        ev_n = 0; done_seen = 0; pll_lat = lat; pll_bad = bad;
        req_valid = 1'b1; req_rate = 16'(rate); cur_pll_code = 4'(cur);
        req_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject != 0) begin
            req_valid = 1'b1; req_rate = 16'd400; cur_pll_code = 4'd9;
            @(negedge clk);
            req_valid = 1'b0;
        end
        guard = 0;
        while (done_seen == 0 && guard < 400) begin
            @(posedge clk);
            guard++;
        end
        if (done_seen == 0) begin
            fails++; checks++;
            $display("FAIL R9 no done: actual 0 expected 1");
            return;
        end
        // build expected sequence
        idx = exp_idx(rate);
        n_exp = 0;
        if (idx < 0) begin
            check("R2", int'(status), 1, "bad-rate status");
            check("R2", ev_n, 0, "events on bad rate");
            check("R9", done_cyc, req_cyc + 1, "done cycle");
        end else begin
            tgt = exp_pll(idx);
            first = (tgt < cur);
            if (first) begin
                e_pll[n_exp] = 1; e_val[n_exp] = tgt; e_addr[n_exp] = 0; n_exp++;
            end
            if (!(first && bad != 0)) begin
                for (int k = 0; k < 16; k++) begin
                    e_pll[n_exp] = 0; e_val[n_exp] = exp_div(idx, k);
                    e_addr[n_exp] = 'h180 + 'h10 * k; n_exp++;
                end
                if (!first) begin
                    e_pll[n_exp] = 1; e_val[n_exp] = tgt; e_addr[n_exp] = 0; n_exp++;
                end
            end
            check("R8", int'(status), (bad != 0) ? 2 : 0, "status");
            check("R6", ev_n, n_exp, "event count");
            ok = 1;
            for (int i = 0; i < n_exp && i < ev_n; i++) begin
                if (ev_pll[i] != e_pll[i] || ev_val[i] != e_val[i] ||
                    ev_addr[i] != e_addr[i]) begin
                    if (ok != 0)
                        $display("FAIL R3/R5/R6 event %0d: actual pll=%0d val=%0d addr=%0h expected pll=%0d val=%0d addr=%0h",
                                 i, ev_pll[i], ev_val[i], ev_addr[i], e_pll[i], e_val[i], e_addr[i]);
                    ok = 0;
                end
                if (i > 0 && ev_pll[i] == 0 && ev_pll[i-1] == 0 &&
                    ev_cyc[i] != ev_cyc[i-1] + 1) begin
                    if (ok != 0)
                        $display("FAIL R4 write gap at %0d: actual %0d expected %0d",
                                 i, ev_cyc[i], ev_cyc[i-1] + 1);
                    ok = 0;
                end
            end
            checks++;
            if (ok == 0) fails++;
            if (ev_n > 0 && ev_n <= 32)
                check("R9", done_cyc, ev_cyc[ev_n-1] + 1, "done after last event");
        end
        if (inject != 0) begin
            ev_before = ev_n;
            repeat (4) @(negedge clk);
            check("R9", int'(busy), 0, "busy after ignored request");
            check("R9", ev_n, ev_before, "events after ignored request");
        end
    endtask

    initial begin
        int r, rate, cur;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(busy), 0, "busy");
        check("R1", int'(done), 0, "done");
        check("R1", int'(pll_req), 0, "pll_req");
        check("R1", int'(div_wr_en), 0, "div_wr_en");
        check("R1", int'(status), 0, "status");

        // directed corners
        run_txn(300, 8, 1, 0, 0);   // R2 unknown rate
        run_txn(0, 8, 0, 0, 0);     // R2
        run_txn(800, 8, 2, 0, 0);   // R6 equal codes: dividers first
        run_txn(600, 8, 3, 0, 0);   // R6 lower target: PLL first, R3 code 6
        run_txn(600, 9, 1, 1, 0);   // R8 failure before dividers
        run_txn(200, 5, 0, 1, 0);   // R8 failure after dividers
        run_txn(400, 9, 4, 0, 1);   // R9 request while busy, PLL first
        run_txn(200, 6, 2, 0, 1);   // R9 request while busy, dividers first
        run_txn(999, 6, 0, 0, 1);   // R2 with injected request
        run_txn(600, 6, 0, 0, 0);   // R5 600 MHz factors, equal code

        // constrained random
        for (int t = 0; t < 60; t++) begin
            r = int'($urandom % 6);
            if (r < 4) rate = (r + 1) * 200;
            else if (r == 4) rate = int'($urandom % 12) * 100;
            else rate = int'($urandom % 2000);
            cur = 5 + int'($urandom % 5);
            run_txn(rate, cur, int'($urandom % 6),
                    ($urandom % 6 == 0) ? 1 : 0, ($urandom % 5 == 0) ? 1 : 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule